// File: doc/BRIEF.md
# Register-Mapped Discrete Pin Controller

This block drives 25 general-purpose digital pins from a simple word-addressed register interface. Twenty-four pins form three 8-bit groups: A, B and C. The last pin is a dedicated extra pin. Software sets which pins drive and which only listen. It writes a latched value that the driving pins present, and it reads back the live level of every pin. Pads are modelled as three vectors: drive value, drive enable and sampled level. The tri-state buffer itself sits outside the block.

Direction is set at two grains. A single bit turns the whole of group A around, and another single bit does the same for group B. Group C has one direction bit per pin. The dedicated pin listens by default. A control bit can make it drive a divided copy of the system clock, with the division ratio fixed at build time. Writing a one to the reset bit of the control register returns the whole block to its idle state at the edge of that same write.

Top module: `pin_io_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `pad_oe` and `pad_out` are all zero, `bus_rdata` is zero, and the control, direction and output registers all read back as zero.
- R2: Direction register (offset 0x4): bit 0 enables all of `pad_oe[7:0]` (group A), bit 1 enables all of `pad_oe[15:8]` (group B), and bits 9:2 each enable one of `pad_oe[23:16]` (group C pin 0 at bit 2). A one means drive and a zero means listen. The new enables appear in the cycle after the write edge. `pad_oe[24]` follows only the clock-mode bit.
- R3: Output register (offset 0x8): bits 23:0 are latched on write and appear on `pad_out[23:0]` whatever the direction setting. Reading 0x8 returns the latched value, not the pin levels.
- R4: Input register (offset 0xC) returns all 25 pin levels on bits 24:0, including pins that are currently driving. Bit 24 is the dedicated pin. Each level passes through a two-stage synchroniser, so a level held for two clock edges before the read edge is returned.
- R5: A read is registered. `bus_rdata` takes the addressed value at the edge where `bus_rd` is sampled high, and it holds its value while `bus_rd` is low.
- R6: Writing a one to bit 0 of the control register (offset 0x0) clears direction, output latch and clock mode at that write edge. Bit 0 always reads back as zero.
- R7: Bit 1 of the control register selects clock mode for the dedicated pin. `pad_oe[24]` is then one and `pad_out[24]` toggles every `DIV_HALF` clocks, first rising `DIV_HALF` edges after the enabling write. With the bit clear, `pad_oe[24]` and `pad_out[24]` are zero.
- R8: Unused register bits read as zero and writes to them are ignored. Writes to offset 0xC have no effect, and offsets other than 0x0, 0x4, 0x8 and 0xC read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pad_out | output | 25 | Drive value per pin; bit 24 is the dedicated pin |
| pad_oe | output | 25 | Drive enable per pin |
| pad_in | input | 25 | Sampled pin level per pin |

## Verification
Register writes take effect at the write edge. The direction and output changes show on `pad_oe` and `pad_out` in the cycle after it, so the bench samples on the falling edge that follows the write strobe. Read data is due one edge after the strobe is sampled. A pin level must precede that read edge by two edges because of the synchroniser, so the bench holds new pin levels for three cycles before it reads the input register. The divided clock is timed by counting falling-edge samples from the enabling write: it is expected to rise after exactly `DIV_HALF` of them and to fall `DIV_HALF` later.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_DIR  = 4;
  localparam int OFS_OUT  = 8;
  localparam int OFS_IN   = 12;

  // control register bits
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_CLK_BIT = 1;

  // direction register bits
  localparam int DIR_A_BIT = 0;
  localparam int DIR_B_BIT = 1;
  localparam int DIR_C_LSB = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DIR,
    SEL_OUT,
    SEL_IN
  } reg_sel_e;
endpackage

// File: rtl/pin_io_regs.sv
module pin_io_regs #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  pin_io_pkg::reg_sel_e    sel,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    soft_rst,
  output logic                    clk_mode,
  output logic [PORT_W+1:0]       dir_q,
  output logic [3*PORT_W-1:0]     out_q
);
  import pin_io_pkg::*;

  localparam int DIR_W = PORT_W + 2;
  localparam int LAT_W = 3 * PORT_W;

  // the reset bit is never stored: it acts at the write edge only
  assign soft_rst = wr && (sel == SEL_CTRL) && wdata[CTRL_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      clk_mode <= 1'b0;
      dir_q    <= '0;
      out_q    <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CTRL: clk_mode <= wdata[CTRL_CLK_BIT];
        SEL_DIR:  dir_q    <= wdata[DIR_W-1:0];
        SEL_OUT:  out_q    <= wdata[LAT_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
  parameter int WIDTH  = 25,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[s] <= '0;
      end else if (s == 0) begin
        chain[s] <= d;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_io_clkdiv.sv
module pin_io_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic clk_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !en) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pin_io_readback.sv
module pin_io_readback #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd,
  input  pin_io_pkg::reg_sel_e    sel,
  input  logic                    clk_mode,
  input  logic [PORT_W+1:0]       dir_q,
  input  logic [3*PORT_W-1:0]     out_q,
  input  logic [3*PORT_W:0]       in_q,
  output logic [DATA_W-1:0]       rdata
);
  import pin_io_pkg::*;

  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    case (sel)
      SEL_CTRL: mux[CTRL_CLK_BIT] = clk_mode;
      SEL_DIR:  mux = DATA_W'(dir_q);
      SEL_OUT:  mux = DATA_W'(out_q);
      SEL_IN:   mux = DATA_W'(in_q);
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= mux;
    end
  end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl #(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [3*PORT_W:0]     pad_out,
  output logic [3*PORT_W:0]     pad_oe,
  input  logic [3*PORT_W:0]     pad_in
);
  import pin_io_pkg::*;

  localparam int PIN_W = 3 * PORT_W + 1;
  localparam int LAT_W = 3 * PORT_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);

  reg_sel_e            sel;
  logic                soft_rst;
  logic                clk_mode;
  logic [PORT_W+1:0]   dir_q;
  logic [LAT_W-1:0]    out_q;
  logic [PIN_W-1:0]    in_q;
  logic                div_clk;

  always_comb begin
    case (bus_addr)
      A_CTRL:  sel = SEL_CTRL;
      A_DIR:   sel = SEL_DIR;
      A_OUT:   sel = SEL_OUT;
      A_IN:    sel = SEL_IN;
      default: sel = SEL_NONE;
    endcase
  end

  pin_io_regs #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .soft_rst (soft_rst),
    .clk_mode (clk_mode),
    .dir_q    (dir_q),
    .out_q    (out_q)
  );

  pin_io_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_q)
  );

  pin_io_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk   (clk),
    .clr   (rst || soft_rst),
    .en    (clk_mode),
    .clk_o (div_clk)
  );

  pin_io_readback #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .sel      (sel),
    .clk_mode (clk_mode),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .in_q     (in_q),
    .rdata    (bus_rdata)
  );

  // group-wide enables for A and B, per-pin enables for C
  for (genvar i = 0; i < PORT_W; i++) begin : g_oe
    assign pad_oe[i]            = dir_q[DIR_A_BIT];
    assign pad_oe[PORT_W + i]   = dir_q[DIR_B_BIT];
    assign pad_oe[2*PORT_W + i] = dir_q[DIR_C_LSB + i];
  end
  assign pad_oe[LAT_W] = clk_mode;

  assign pad_out = {div_clk & clk_mode, out_q};
endmodule

// File: rtl/pin_io_ctrl_chk.sv
module pin_io_ctrl_chk #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [3*PORT_W:0]     pad_out,
  input logic [3*PORT_W:0]     pad_oe
);
  localparam int LAT_W = 3 * PORT_W;
  localparam int DIR_W = PORT_W + 2;

  p_group_a_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(pad_oe[PORT_W-1:0]) == 0) || ($countones(pad_oe[PORT_W-1:0]) == PORT_W));

  p_group_b_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(pad_oe[2*PORT_W-1:PORT_W]) == 0) || ($countones(pad_oe[2*PORT_W-1:PORT_W]) == PORT_W));

  p_latch_write_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(8)) |=> (pad_out[LAT_W-1:0] == $past(bus_wdata[LAT_W-1:0])));

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[0]) |=> (pad_oe == '0 && pad_out == '0));

  p_clk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !pad_oe[LAT_W] |-> !pad_out[LAT_W]);

  p_dir_unused_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4)) |=> (bus_rdata[DATA_W-1:DIR_W] == '0));
endmodule

bind pin_io_ctrl pin_io_ctrl_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/pin_io_ctrl_test.sv
`timescale 1ns/1ps
module pin_io_ctrl_test;
  localparam int DIV_HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [24:0] pad_out, pad_oe, pad_in;
  logic [24:0] ext_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // pad resolution: a driving pin reads back its own value
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  pin_io_ctrl #(.DIV_HALF(DIV_HALF)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  // {addr, wdata, expected readback, expected pad_oe}
  localparam logic [92:0] VEC [0:5] = '{
    {4'h4, 32'h0000_0001, 32'h0000_0001, 25'h00_00FF},
    {4'h4, 32'hFFFF_FC02, 32'h0000_0002, 25'h00_FF00},
    {4'h4, 32'h0000_0154, 32'h0000_0154, 25'h55_0000},
    {4'h4, 32'h0000_03FF, 32'h0000_03FF, 25'hFF_FFFF},
    {4'h8, 32'hFFA5_5AC3, 32'h00A5_5AC3, 25'hFF_FFFF},
    {4'h2, 32'hFFFF_FFFF, 32'h0000_0000, 25'hFF_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int rise_at, fall_at;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(4'h0, rd); check("R1 ctrl", rd, 32'h0);
    bus_read(4'h4, rd); check("R1 dir", rd, 32'h0);
    bus_read(4'h8, rd); check("R1 out", rd, 32'h0);

    // R2 R3 R8 vector table
    foreach (VEC[i]) begin
      bus_write(VEC[i][92:89], VEC[i][88:57]);
      check("R2 pad_oe vector", 32'(pad_oe), 32'(VEC[i][24:0]));
      bus_read(VEC[i][92:89], rd);
      check("R8 readback vector", rd, VEC[i][56:25]);
    end

    // R3 latch drives pins regardless of direction, reads return latch
    bus_write(4'h4, 32'h0);
    check("R3 pad_out with dir 0", 32'(pad_out), 32'h00A5_5AC3);
    bus_read(4'h8, rd); check("R3 latch readback", rd, 32'h00A5_5AC3);

    // R4 input register, all listening
    ext_in = 25'h13C_5A96;
    repeat (3) @(negedge clk);
    bus_read(4'hC, rd); check("R4 input all listening", rd, 32'h013C_5A96);

    // R4 driving pins read their own level
    ext_in = 25'h100_0000;
    bus_write(4'h4, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(4'hC, rd); check("R4 input group A driving", rd, 32'h0100_00C3);
    bus_write(4'h4, 32'h3FF);
    repeat (3) @(negedge clk);
    bus_read(4'hC, rd); check("R4 input all driving", rd, 32'h01A5_5AC3);

    // R8 writes to the input register are ignored
    bus_write(4'hC, 32'h0000_0000);
    bus_read(4'h8, rd); check("R8 out after write to 0xC", rd, 32'h00A5_5AC3);
    bus_read(4'h4, rd); check("R8 dir after write to 0xC", rd, 32'h0000_03FF);

    // R5 read data holds without a strobe
    bus_read(4'h8, rd);
    bus_write(4'h8, 32'h0012_3456);
    repeat (2) @(negedge clk);
    check("R5 rdata held", bus_rdata, 32'h00A5_5AC3);
    bus_read(4'h8, rd); check("R5 new read", rd, 32'h0012_3456);

    // R7 clock mode; R8 unused control bits
    bus_write(4'h0, 32'hFFFF_FFFE);
    check("R7 pad_oe[24] set", 32'(pad_oe[24]), 32'h1);
    bus_read(4'h0, rd); check("R8 ctrl unused bits", rd, 32'h2);
    bus_write(4'h0, 32'h0);
    check("R7 pad_out[24] idle", 32'(pad_out[24]), 32'h0);
    check("R7 pad_oe[24] clear", 32'(pad_oe[24]), 32'h0);
    bus_write(4'h0, 32'h2);
    rise_at = -1; fall_at = -1;
    for (int k = 1; k <= 3 * DIV_HALF; k++) begin
      @(negedge clk);
      if (pad_out[24] && rise_at < 0) rise_at = k;
      if (!pad_out[24] && rise_at >= 0 && fall_at < 0) fall_at = k;
    end
    check("R7 first rise", 32'(rise_at), 32'(DIV_HALF));
    check("R7 high time", 32'(fall_at - rise_at), 32'(DIV_HALF));

    // R6 soft reset clears everything at the write edge
    bus_write(4'h0, 32'h3);
    check("R6 pad_oe", 32'(pad_oe), 32'h0);
    check("R6 pad_out", 32'(pad_out), 32'h0);
    bus_read(4'h0, rd); check("R6 ctrl", rd, 32'h0);
    bus_read(4'h4, rd); check("R6 dir", rd, 32'h0);
    bus_read(4'h8, rd); check("R6 out", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule